// File: doc/BRIEF.md
# Banked Memory Address and Line Decoder

This block turns a 12-bit processor address into a physical location inside a 2K-word writable core store built as eight banks of 256 words. It first decides whether the address falls in the writable space at all. It then works out which bank is meant. Three of the four quarters of the 1K window name banks 0, 1 and 2 outright. The top quarter, addresses 768 to 1023, is sent to whichever bank a small bank register currently holds.

From the address offset and the resolved bank, the block drives select lines for a coincident-current array: one of 64 X rows and one of 32 Y lines. The X row comes only from address bits. The Y line is formed by an address-chosen group of eight lines, with the resolved bank choosing the line inside that group. All outputs are registered and appear one clock after the address is presented.

Top module: `bank_line_decoder`

## Requirements
- R1: `hit` goes high one cycle after an address whose bits 11 and 10 are both zero is presented, and is low one cycle after any other address.
- R2: When address bits 9:8 are 00, 01 or 10, `bank` shows 0, 1 or 2 respectively one cycle later.
- R3: When address bits 9:8 are 11, `bank` shows the bank register contents held at the clock edge that samples the address; a load at that same edge affects only later addresses.
- R4: The bank register takes `bank_wr_data` at a rising edge where `bank_wr_en` is high, keeps its value otherwise, and holds 0 after reset.
- R5: `word_idx` equals the resolved bank in bits 10:8 and address bits 7:0 in bits 7:0.
- R6: When `hit` is high, exactly one bit of `x_sel` is set, at index address[2:0]*8 + address[5:3].
- R7: When `hit` is high, exactly one bit of `y_sel` is set, at index address[7:6]*8 + resolved bank.
- R8: When `hit` is low, every bit of `x_sel` and `y_sel` is zero; `bank` and `word_idx` are still resolved as in R2, R3 and R5.
- R9: While reset is high and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Address to decode |
| bank_wr_en | input | 1 | Load strobe for the bank register |
| bank_wr_data | input | 3 | Value loaded into the bank register |
| hit | output | 1 | Address lies in writable storage |
| bank | output | 3 | Resolved bank number |
| word_idx | output | 11 | Physical word index in the 2K store |
| x_sel | output | 64 | One-hot X row select |
| y_sel | output | 32 | One-hot Y line select |

## Verification
The assertions assume `addr`, `bank_wr_en` and `bank_wr_data` are always known values and change only away from the rising edge, and they skip the first cycle after reset, whose outputs still carry the reset values. The stimulus drives every input bit to a defined value on the falling edge. It draws addresses from a seeded generator, which spreads them across all four 9:8 cases and both writable and non-writable space, and it adds directed cases for bank loads at the same edge as a register-routed address.

// File: rtl/bld_pkg.sv
package bld_pkg;
  // Default geometry of the decoded store
  localparam int OFS_W_D   = 8;  // word offset inside a bank
  localparam int BANK_W_D  = 3;  // bank number width
  localparam int XGRP_W_D  = 3;  // X group field, lowest address bits
  localparam int XLINE_W_D = 3;  // X line-in-group field
  localparam int YGRP_W_D  = 2;  // Y group field, top offset bits

  // Decision of the resolve stage
  typedef struct packed {
    logic       hit;
    logic [7:0] bank;  // wide holder, trimmed by users
  } resolve_t;
endpackage

// File: rtl/bld_bank_reg.sv
module bld_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BANK_W-1:0] d,
  output logic [BANK_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/bld_bank_resolve.sv
module bld_bank_resolve #(
  parameter int OFS_W  = 8,
  parameter int BANK_W = 3,
  localparam int ADDR_W = OFS_W + 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] reg_bank,
  output logic              hit,
  output logic [BANK_W-1:0] bank
);
  logic [1:0] space_f;
  logic [1:0] quarter_f;

  assign space_f   = addr[OFS_W+3:OFS_W+2];
  assign quarter_f = addr[OFS_W+1:OFS_W];

  always_comb begin
    hit = (space_f == 2'b00);
    if (quarter_f == 2'b11) bank = reg_bank;
    else                    bank = BANK_W'(quarter_f);
  end
endmodule

// File: rtl/bld_onehot.sv
module bld_onehot #(
  parameter int IDX_W = 6,
  localparam int N = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bank_line_decoder.sv
module bank_line_decoder
  import bld_pkg::*;
#(
  parameter int OFS_W   = OFS_W_D,
  parameter int BANK_W  = BANK_W_D,
  parameter int XGRP_W  = XGRP_W_D,
  parameter int XLINE_W = XLINE_W_D,
  parameter int YGRP_W  = YGRP_W_D,
  localparam int ADDR_W = OFS_W + 4,
  localparam int WORD_W = BANK_W + OFS_W,
  localparam int XIDX_W = XGRP_W + XLINE_W,
  localparam int YIDX_W = YGRP_W + BANK_W,
  localparam int XN     = 1 << XIDX_W,
  localparam int YN     = 1 << YIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_wr_en,
  input  logic [BANK_W-1:0] bank_wr_data,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output logic [WORD_W-1:0] word_idx,
  output logic [XN-1:0]     x_sel,
  output logic [YN-1:0]     y_sel
);
  logic [BANK_W-1:0] reg_bank;
  logic              hit_c;
  logic [BANK_W-1:0] bank_c;
  logic [XIDX_W-1:0] x_idx;
  logic [YIDX_W-1:0] y_idx;
  logic [XN-1:0]     x_c;
  logic [YN-1:0]     y_c;

  bld_bank_reg #(.BANK_W(BANK_W)) u_reg (
    .clk(clk), .rst(rst), .we(bank_wr_en), .d(bank_wr_data), .q(reg_bank)
  );

  bld_bank_resolve #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_res (
    .addr(addr), .reg_bank(reg_bank), .hit(hit_c), .bank(bank_c)
  );

  // X: group in the low bits is the major index, line-in-group the minor
  assign x_idx = {addr[XGRP_W-1:0], addr[XIDX_W-1:XGRP_W]};
  // Y: address group is major, resolved bank picks the line
  assign y_idx = {addr[OFS_W-1:OFS_W-YGRP_W], bank_c};

  bld_onehot #(.IDX_W(XIDX_W)) u_xdec (.en(hit_c), .idx(x_idx), .sel(x_c));
  bld_onehot #(.IDX_W(YIDX_W)) u_ydec (.en(hit_c), .idx(y_idx), .sel(y_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      bank     <= '0;
      word_idx <= '0;
      x_sel    <= '0;
      y_sel    <= '0;
    end else begin
      hit      <= hit_c;
      bank     <= bank_c;
      word_idx <= {bank_c, addr[OFS_W-1:0]};
      x_sel    <= x_c;
      y_sel    <= y_c;
    end
  end
endmodule

// File: rtl/bld_chk.sv
module bld_chk #(
  parameter int OFS_W  = 8,
  parameter int BANK_W = 3,
  parameter int XN     = 64,
  parameter int YN     = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [OFS_W+3:0]        addr,
  input logic                    hit,
  input logic [BANK_W-1:0]       bank,
  input logic [BANK_W+OFS_W-1:0] word_idx,
  input logic [XN-1:0]           x_sel,
  input logic [YN-1:0]           y_sel
);
  logic live;  // high once outputs reflect a decoded address
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  a_r1_hit_space: assert property (@(posedge clk) disable iff (rst)
    live |-> (hit == ($past(addr[OFS_W+3:OFS_W+2]) == 2'b00)));

  a_r2_direct_bank: assert property (@(posedge clk) disable iff (rst)
    (live && $past(addr[OFS_W+1:OFS_W]) != 2'b11)
      |-> (bank == BANK_W'($past(addr[OFS_W+1:OFS_W]))));

  a_r5_word_offset: assert property (@(posedge clk) disable iff (rst)
    live |-> (word_idx == {bank, $past(addr[OFS_W-1:0])}));

  a_r6_x_onehot: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($countones(x_sel) == 1));

  a_r7_y_onehot: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($countones(y_sel) == 1));

  a_r8_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (x_sel == '0 && y_sel == '0));

  a_r9_after_reset: assert property (@(posedge clk)
    (live == 1'b0 && !rst) |-> (!hit && x_sel == '0 && y_sel == '0));
endmodule

bind bank_line_decoder bld_chk #(
  .OFS_W(OFS_W), .BANK_W(BANK_W), .XN(XN), .YN(YN)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .hit(hit), .bank(bank),
  .word_idx(word_idx), .x_sel(x_sel), .y_sel(y_sel)
);

// File: tb/tb_bank_line_decoder.sv
module tb_bank_line_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic        bank_wr_en;
  logic [2:0]  bank_wr_data;
  logic        hit;
  logic [2:0]  bank;
  logic [10:0] word_idx;
  logic [63:0] x_sel;
  logic [31:0] y_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] mdl_bank;

  bank_line_decoder dut (
    .clk(clk), .rst(rst), .addr(addr), .bank_wr_en(bank_wr_en),
    .bank_wr_data(bank_wr_data), .hit(hit), .bank(bank),
    .word_idx(word_idx), .x_sel(x_sel), .y_sel(y_sel)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_bank(input logic [11:0] a, input logic [2:0] rb);
    return (a[9:8] == 2'b11) ? rb : {1'b0, a[9:8]};
  endfunction

  function automatic logic [63:0] exp_x(input logic [11:0] a);
    logic [63:0] v = '0;
    if (a[11:10] == 2'b00) v[{a[2:0], a[5:3]}] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_y(input logic [11:0] a, input logic [2:0] b);
    logic [31:0] v = '0;
    if (a[11:10] == 2'b00) v[{a[7:6], b}] = 1'b1;
    return v;
  endfunction

  // Drive one address on the falling edge, check one cycle later
  task automatic step(input logic [11:0] a, input bit we, input logic [2:0] wd);
    logic [2:0] eb;
    bit         eh;
    addr = a; bank_wr_en = we; bank_wr_data = wd;
    eb = exp_bank(a, mdl_bank);   // register value before this edge (R3)
    eh = (a[11:10] == 2'b00);
    @(negedge clk);
    if (we) mdl_bank = wd;         // R4 load model
    chk(hit == eh, "R1 hit", 64'(hit), 64'(eh));
    chk(bank == eb, (a[9:8] == 2'b11) ? "R3 reg bank" : "R2 direct bank",
        64'(bank), 64'(eb));
    chk(word_idx == {eb, a[7:0]}, "R5 word_idx", 64'(word_idx), 64'({eb, a[7:0]}));
    chk(x_sel == exp_x(a), eh ? "R6 x_sel" : "R8 x_sel idle", x_sel, exp_x(a));
    chk(y_sel == exp_y(a, eb), eh ? "R7 y_sel" : "R8 y_sel idle",
        64'(y_sel), 64'(exp_y(a, eb)));
  endtask

  initial begin
    void'($urandom(32'd20181014));
    rst = 1'b1; addr = 12'h3FF; bank_wr_en = 1'b1; bank_wr_data = 3'd6;
    mdl_bank = 3'd0;
    repeat (3) @(negedge clk);
    // R9: outputs zero while in reset, register not loaded
    chk(hit == 0 && bank == 0 && word_idx == 0 && x_sel == 0 && y_sel == 0,
        "R9 reset outputs", {hit, bank, word_idx}, 64'd0);
    rst = 1'b0; bank_wr_en = 1'b0;
    chk(hit == 0 && x_sel == 0 && y_sel == 0, "R9 first cycle", 64'(hit), 64'd0);
    // R4: register reads 0 after reset
    step(12'h3C5, 0, 3'd0);
    // R3: load at the same edge is not seen by this address
    step(12'h3AA, 1, 3'd7);
    step(12'h3AA, 0, 3'd0);
    // R2 direct quarters, corners
    step(12'h000, 0, 3'd0);
    step(12'h1FF, 0, 3'd0);
    step(12'h2FF, 0, 3'd0);
    // R8: outside writable space, with register-routed quarter
    step(12'hC00, 0, 3'd0);
    step(12'h7FF, 1, 3'd4);
    step(12'h3FF, 0, 3'd0);
    for (int i = 0; i < 400; i++) begin
      step(12'($urandom), ($urandom % 4) == 0, 3'($urandom));
    end
    // R4: held value without a write
    step(12'h340, 0, 3'd5);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule